// File: doc/BRIEF.md
# Byte-Wide Host Command Port

This block is the device end of an 8-bit parallel host port. The host carries single-byte commands and 16-bit data words over it. Four control lines come from the host, all sampled on the system clock: an active-low select, an active-low read strobe, an active-low write strobe, and a line that marks a written byte as either a command or data. The port drives a ready/busy flag and an active-low interrupt back to the host. The byte bus is shown here as a separate input, an output and an output enable, so the pad ring can build the tri-state driver.

Each completed host transaction goes to the internal logic as one item on a valid/ack channel. An item carries a kind code and a 16-bit word. The port stays busy from the moment it offers an item until the internal side acknowledges it. The internal side holds the outbound word steady on a plain input, and the host reads that word as two bytes.

A host access is counted at the end of its strobe, meaning the clock cycle in which the synchronised strobe-and-select pair goes inactive. Any access made while the port is busy is discarded, and it sets a sticky error flag.

Top module: `host_byte_port`

## Requirements
- R1: After reset, `rdy` is 1, `irq_n` is 1, `in_valid` is 0, `proto_err` is 0, and a byte-phase toggle points at the high byte.
- R2: A byte written while `cmd_sel` is 1 is offered as an item of kind 0 (command), with the byte in `in_word[7:0]` and `in_word[15:8]` zero.
- R3: With `cmd_sel` at 0, two written bytes form one item of kind 1 (data write). The first byte lands in `in_word[15:8]` and the second in `in_word[7:0]`.
- R4: `rdy` falls when an item is offered, which happens after a command byte or after the second byte of a data word. It stays 1 after the first byte of a word.
- R5: `in_valid`, `in_kind` and `in_word` hold steady until a cycle with `in_ack` at 1. In the cycle after that, `in_valid` is 0 and `rdy` is 1. `rdy` never rises without such an ack, and each transaction produces exactly one item.
- R6: The first read presents `out_word[15:8]` on `bus_out` and the second read presents `out_word[7:0]`. The second read then offers an item of kind 2 (read done) with a zero word.
- R7: `bus_oe` is 1 exactly while `sel_n` and `rd_n` are both 0.
- R8: A read or write that ends while `rdy` is 0 produces no item and leaves the byte phase alone. It sets `proto_err`, which only reset clears.
- R9: `irq_n` is 0 in the cycle after any bit of `irq_pend & irq_en` is 1, and 1 in the cycle after none is.
- R10: A strobe pulsed while `sel_n` is 1 is not counted as an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Host select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| cmd_sel | input | 1 | 1 marks a written byte as a command, 0 as data |
| bus_in | input | 8 | Byte from the host bus |
| bus_out | output | 8 | Byte driven toward the host on reads |
| bus_oe | output | 1 | Enable for the tri-state bus driver |
| rdy | output | 1 | 1 = port ready, 0 = busy |
| irq_n | output | 1 | Interrupt to host, active low |
| irq_pend | input | IRQ_N | Pending interrupt conditions |
| irq_en | input | IRQ_N | Interrupt enables |
| in_valid | output | 1 | Item offered to the internal side |
| in_kind | output | 2 | 0 command, 1 data write, 2 read done |
| in_word | output | 16 | Item payload |
| in_ack | input | 1 | Internal side has processed the item |
| out_word | input | 16 | Word the host reads, held steady by the internal side |
| proto_err | output | 1 | Sticky: an access arrived while busy |

## Verification
The assertions assume the host keeps `bus_in` and `cmd_sel` steady from the start of a write strobe until several clocks after that strobe rises. They also assume `out_word` does not change during a read pair. Finally, they assume the internal side raises `in_ack` only while `in_valid` is 1. The bench host tasks hold the data lines four clocks past each strobe edge, and the bench changes `out_word` only between transactions. The bench monitor acknowledges an item only when it sees `in_valid`. It can withhold the ack to keep the port busy for the busy-access cases.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
    typedef enum logic [1:0] {
        KIND_CMD   = 2'd0,
        KIND_WDATA = 2'd1,
        KIND_RDONE = 2'd2
    } hbp_kind_e;
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else if (s == 0) chain_q[s] <= d;
            else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hbp_irq.sv
module hbp_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend,
    input  logic [N-1:0] en,
    output logic         irq_n
);
    logic irq_n_d, irq_n_q;

    always_comb irq_n_d = ~|(pend & en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_n_q <= 1'b1;
        else        irq_n_q <= irq_n_d;
    end

    assign irq_n = irq_n_q;

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & en)) |=> !irq_n_q); // R9
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend & en)) |=> irq_n_q); // R9
endmodule

// File: rtl/host_byte_port.sv
module host_byte_port
    import hbp_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int IRQ_N     = 4,
    parameter int SYNC_STG  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_n,
    input  logic                rd_n,
    input  logic                wr_n,
    input  logic                cmd_sel,
    input  logic [BYTE_W-1:0]   bus_in,
    output logic [BYTE_W-1:0]   bus_out,
    output logic                bus_oe,
    output logic                rdy,
    output logic                irq_n,
    input  logic [IRQ_N-1:0]    irq_pend,
    input  logic [IRQ_N-1:0]    irq_en,
    output logic                in_valid,
    output logic [1:0]          in_kind,
    output logic [2*BYTE_W-1:0] in_word,
    input  logic                in_ack,
    input  logic [2*BYTE_W-1:0] out_word,
    output logic                proto_err
);
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic              rdy;
        logic              phase;   // 0 = high byte next, 1 = low byte next
        logic [BYTE_W-1:0] hi;
        logic [WORD_W-1:0] word;
        hbp_kind_e         kind;
        logic              valid;
        logic              err;
        logic              wr_act;
        logic              rd_act;
    } st_t;

    st_t st_d, st_q;

    logic [2:0] pins_s;
    logic       sel_s, rd_s, wr_s;

    hbp_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sel_n, rd_n, wr_n}),
        .q     (pins_s)
    );
    assign {sel_s, rd_s, wr_s} = pins_s;

    hbp_irq #(.N(IRQ_N)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (irq_pend),
        .en    (irq_en),
        .irq_n (irq_n)
    );

    logic wr_act_now, rd_act_now, wr_end, rd_end;
    assign wr_act_now = ~wr_s & ~sel_s;
    assign rd_act_now = ~rd_s & ~sel_s;
    assign wr_end     = st_q.wr_act & ~wr_act_now;
    assign rd_end     = st_q.rd_act & ~rd_act_now;

    always_comb begin
        st_d        = st_q;
        st_d.wr_act = wr_act_now;
        st_d.rd_act = rd_act_now;

        if (st_q.valid && in_ack) begin
            st_d.valid = 1'b0;
            st_d.rdy   = 1'b1;
        end

        if (wr_end || rd_end) begin
            if (!st_q.rdy) begin
                st_d.err = 1'b1;
            end else if (wr_end) begin
                if (cmd_sel) begin
                    st_d.word  = {{BYTE_W{1'b0}}, bus_in};
                    st_d.kind  = KIND_CMD;
                    st_d.valid = 1'b1;
                    st_d.rdy   = 1'b0;
                    st_d.phase = 1'b0;
                end else if (!st_q.phase) begin
                    st_d.hi    = bus_in;
                    st_d.phase = 1'b1;
                end else begin
                    st_d.word  = {st_q.hi, bus_in};
                    st_d.kind  = KIND_WDATA;
                    st_d.valid = 1'b1;
                    st_d.rdy   = 1'b0;
                    st_d.phase = 1'b0;
                end
            end else begin
                if (!st_q.phase) begin
                    st_d.phase = 1'b1;
                end else begin
                    st_d.word  = '0;
                    st_d.kind  = KIND_RDONE;
                    st_d.valid = 1'b1;
                    st_d.rdy   = 1'b0;
                    st_d.phase = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.rdy    <= 1'b1;
            st_q.kind   <= KIND_CMD;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_oe    = ~sel_n & ~rd_n;
    assign bus_out   = st_q.phase ? out_word[BYTE_W-1:0] : out_word[WORD_W-1:BYTE_W];
    assign rdy       = st_q.rdy;
    assign in_valid  = st_q.valid;
    assign in_kind   = st_q.kind;
    assign in_word   = st_q.word;
    assign proto_err = st_q.err;

    AST_RDY_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(rdy && in_valid)); // R4
    AST_RDY_FALL_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> in_valid); // R4
    AST_RDY_RISE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(in_valid && in_ack)); // R5
    AST_ITEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ack) |=> (in_valid && $stable(in_word) && $stable(in_kind))); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R8
    AST_CMD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == KIND_CMD) |-> (in_word[WORD_W-1:BYTE_W] == '0)); // R2
endmodule

// File: tb/host_byte_port_bench.sv
module host_byte_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cmd_sel = 1'b0;
    logic [7:0]  bus_in = '0;
    logic [7:0]  bus_out;
    logic        bus_oe, rdy, irq_n, in_valid, proto_err;
    logic [3:0]  irq_pend = '0, irq_en = '0;
    logic [1:0]  in_kind;
    logic [15:0] in_word;
    logic        in_ack = 1'b0;
    logic [15:0] out_word = '0;
    logic        hold_ack = 1'b0;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [17:0] exp_q [$];

    always #10 clk = ~clk;

    host_byte_port u_host_byte_port (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
        .cmd_sel(cmd_sel), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .rdy(rdy), .irq_n(irq_n), .irq_pend(irq_pend), .irq_en(irq_en),
        .in_valid(in_valid), .in_kind(in_kind), .in_word(in_word),
        .in_ack(in_ack), .out_word(out_word), .proto_err(proto_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    // Monitor: scoreboard compare and ack on the internal side (R2 R3 R5 R6)
    always @(negedge clk) begin
        in_ack <= 1'b0;
        if (rst_n && in_valid && !in_ack && !hold_ack) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected item", {14'd0, in_kind, in_word}, 32'd0);
            end else begin
                logic [17:0] e;
                e = exp_q.pop_front();
                chk({in_kind, in_word} == e, "R2/R3/R6 item", {14'd0, in_kind, in_word}, {14'd0, e});
            end
            in_ack <= 1'b1;
        end
    end

    task automatic wait_rdy();
        while (!rdy) @(negedge clk);
    endtask

    task automatic host_wr(input logic c, input logic [7:0] b, input bit wait_first);
        if (wait_first) wait_rdy();
        @(negedge clk);
        cmd_sel = c; bus_in = b; sel_n = 1'b0;
        @(negedge clk); wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        sel_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic host_rd(output logic [7:0] b, output logic oe, input bit wait_first);
        if (wait_first) wait_rdy();
        @(negedge clk);
        sel_n = 1'b0;
        @(negedge clk); rd_n = 1'b0;
        repeat (2) @(negedge clk);
        b = bus_out; oe = bus_oe;
        @(negedge clk); rd_n = 1'b1;
        repeat (4) @(negedge clk);
        sel_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        wait_rdy();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [7:0] rb;
        logic       oe;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rdy == 1'b1, "R1 rdy", rdy, 1);
        chk(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
        chk(in_valid == 1'b0, "R1 in_valid", in_valid, 0);
        chk(bus_oe == 1'b0, "R7 bus_oe idle", bus_oe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(proto_err == 1'b0, "R1 proto_err", proto_err, 0);

        // R2 command bytes
        exp_q.push_back({2'd0, 16'h00A5});
        host_wr(1'b1, 8'hA5, 1'b1);
        drain();
        exp_q.push_back({2'd0, 16'h003C});
        host_wr(1'b1, 8'h3C, 1'b1);
        drain();

        // R3/R4 data word, high byte first; rdy stays up after first byte
        host_wr(1'b0, 8'h12, 1'b1);
        chk(rdy == 1'b1, "R4 rdy after first byte", rdy, 1);
        chk(in_valid == 1'b0, "R4 no item after first byte", in_valid, 0);
        exp_q.push_back({2'd1, 16'h1234});
        host_wr(1'b0, 8'h34, 1'b1);
        drain();
        exp_q.push_back({2'd1, 16'hFE01});
        host_wr(1'b0, 8'hFE, 1'b1);
        host_wr(1'b0, 8'h01, 1'b1);
        drain();

        // R6 read word, high then low
        out_word = 16'hBEEF;
        host_rd(rb, oe, 1'b1);
        chk(rb == 8'hBE, "R6 first read byte", rb, 8'hBE);
        chk(oe == 1'b1, "R7 bus_oe during read", oe, 1);
        chk(rdy == 1'b1, "R4 rdy after first read", rdy, 1);
        exp_q.push_back({2'd2, 16'h0000});
        host_rd(rb, oe, 1'b1);
        chk(rb == 8'hEF, "R6 second read byte", rb, 8'hEF);
        drain();

        // R7 read strobe without select does not enable driver
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk);
        chk(bus_oe == 1'b0, "R7 bus_oe without select", bus_oe, 0);
        rd_n = 1'b1;

        // R10 strobe without select ignored
        @(negedge clk); cmd_sel = 1'b1; bus_in = 8'h77; wr_n = 1'b0;
        repeat (3) @(negedge clk); wr_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(rdy == 1'b1 && in_valid == 1'b0, "R10 unselected write ignored", {in_valid, rdy}, 2'b01);

        // R5/R8 busy handling: withhold ack, access during busy
        hold_ack = 1'b1;
        exp_q.push_back({2'd0, 16'h0055});
        host_wr(1'b1, 8'h55, 1'b1);
        chk(rdy == 1'b0, "R4 rdy low after command", rdy, 0);
        host_wr(1'b1, 8'h66, 1'b0);
        chk(proto_err == 1'b1, "R8 error set on busy write", proto_err, 1);
        chk(in_word == 16'h0055, "R8 busy write ignored", in_word, 16'h0055);
        repeat (10) @(negedge clk);
        chk(rdy == 1'b0 && in_valid == 1'b1, "R5 rdy held without ack", {in_valid, rdy}, 2'b10);
        hold_ack = 1'b0;
        drain();
        chk(rdy == 1'b1, "R5 rdy after ack", rdy, 1);
        chk(proto_err == 1'b1, "R8 error sticky", proto_err, 1);

        // R8 busy access leaves phase alone: next word still pairs correctly
        hold_ack = 1'b1;
        exp_q.push_back({2'd0, 16'h0011});
        host_wr(1'b1, 8'h11, 1'b1);
        host_wr(1'b0, 8'h99, 1'b0);
        hold_ack = 1'b0;
        drain();
        exp_q.push_back({2'd1, 16'hCAFE});
        host_wr(1'b0, 8'hCA, 1'b1);
        host_wr(1'b0, 8'hFE, 1'b1);
        drain();

        // R9 interrupt
        irq_pend = 4'b0100; irq_en = 4'b0011;
        repeat (3) @(negedge clk);
        chk(irq_n == 1'b1, "R9 masked pending", irq_n, 1);
        irq_en = 4'b0100;
        repeat (2) @(negedge clk);
        chk(irq_n == 1'b0, "R9 enabled pending", irq_n, 0);
        irq_pend = 4'b0000;
        repeat (2) @(negedge clk);
        chk(irq_n == 1'b1, "R9 cleared", irq_n, 1);

        // R1 reset clears sticky error
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(proto_err == 1'b0 && rdy == 1'b1, "R1 reset clears error", {proto_err, rdy}, 2'b01);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        chk(exp_q.size() == 0, "R5 every item delivered", exp_q.size(), 0);
        finish_run();
    end
endmodule